// File: doc/BRIEF.md
# Leg Dead-Band Generator with Current-Sign Correction

This block drives one leg of a two-level inverter. Each clock it takes the shared carrier count, the requested high-side compare value, the carrier period, a dead-band length in clock cycles and a signed sample of the leg's phase current. From these it produces the high-side and low-side gate commands. The two gates are never on together. Each gate's turn-on is held back by the dead-band length, and both gates stay off while it runs.

A dead band shifts the average leg voltage by an amount whose sign follows the current. The block offsets that shift by moving the compare value. A positive current lengthens the requested on-time by the dead-band count. A negative current shortens it by the same count. The current sign passes through a hysteresis band, so noise around zero current does not flip it. The corrected compare is limited to the range from zero to the carrier period, and it is also made visible as an output.

Top module: `deadband_leg`

## Requirements
- R1: While reset is held, and after it is released until the first clock edge, both gates are off. The current sign resets to positive.
- R2: The high-side and low-side gates are never on in the same cycle.
- R3: When the demand changes level, the gate for the new level turns on only after the new level has been sampled on `dead`+1 consecutive clock edges. Until then both gates are off.
- R4: A gate turns off at the first clock edge that samples the opposite demand.
- R5: A demand pulse that lasts `dead` samples or fewer produces no pulse on the matching gate.
- R6: A current sample greater than +HYST sets the sign to positive. A sample less than -HYST sets it to negative. A sample inside the closed band [-HYST, +HYST] keeps the previous sign. The sign is registered on each clock edge.
- R7: The corrected compare is `compare`+`dead` when the sign is positive and `compare`-`dead` when it is negative.
- R8: The corrected compare `cmp_out` is clamped to the range 0 to `period`.
- R9: The high-side demand is 1 while `carrier` < `cmp_out`, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| carrier | input | CW | Carrier counter value |
| period | input | CW | Carrier period, upper clamp for the corrected compare |
| compare | input | CW | Requested high-side compare value |
| dead | input | DTW | Dead-band length in clock cycles |
| current | input | IW | Signed phase-current sample |
| gate_hi | output | 1 | High-side gate command |
| gate_lo | output | 1 | Low-side gate command |
| cmp_out | output | CW | Corrected, clamped compare value |

## Verification
The bench builds the block with a 6-bit carrier, a 3-bit dead-band field, an 8-bit current and a hysteresis of 4, and uses a carrier period of 20. With these values the sweep covers every dead-band length from 0 to 7 against every compare value from 0 to 22. The range therefore includes compares above the period and compares shorter than the dead band, so both clamp limits and the suppressed short pulse are exercised. Four current patterns are applied: steady positive, steady negative, a sign set once and then held by in-band samples, and a noisy zero crossing. Together they exercise every way the sign can be kept or changed.

// File: rtl/deadband_leg.sv
module deadband_leg #(
  parameter int CW   = 8,
  parameter int DTW  = 3,
  parameter int IW   = 10,
  parameter int HYST = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        carrier,
  input  logic [CW-1:0]        period,
  input  logic [CW-1:0]        compare,
  input  logic [DTW-1:0]       dead,
  input  logic signed [IW-1:0] current,
  output logic                 gate_hi,
  output logic                 gate_lo,
  output logic [CW-1:0]        cmp_out
);
  localparam int AW = DTW + 1;
  localparam logic [AW-1:0] AMAX = '1;
  localparam logic signed [IW-1:0] HPOS = IW'(HYST);
  localparam logic signed [IW-1:0] HNEG = -IW'(HYST);

  logic          pos;
  logic          lvl;
  logic [AW-1:0] age;
  logic [AW-1:0] age_nx;
  logic          demand;
  logic          settled;
  logic signed [CW+1:0] adj;
  logic signed [CW+1:0] dext;
  logic signed [CW+1:0] cext;
  logic signed [CW+1:0] pext;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              pos <= 1'b1;
    else if (current > HPOS) pos <= 1'b1;
    else if (current < HNEG) pos <= 1'b0;

  assign dext = $signed({{(CW+2-DTW){1'b0}}, dead});
  assign cext = $signed({2'b00, compare});
  assign pext = $signed({2'b00, period});
  assign adj  = pos ? cext + dext : cext - dext;
  assign cmp_out = (adj < 0) ? '0 : (adj > pext) ? period : adj[CW-1:0];

  assign demand  = carrier < cmp_out;
  assign age_nx  = (demand != lvl) ? AW'(1) : (age == AMAX) ? AMAX : age + AW'(1);
  assign settled = age_nx > {1'b0, dead};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl     <= 1'b0;
      age     <= '0;
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else begin
      lvl     <= demand;
      age     <= age_nx;
      gate_hi <= demand & settled;
      gate_lo <= ~demand & settled;
    end

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  assert_dead_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi) && $past(dead) != 0) |-> !$past(gate_lo));

  assert_fast_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !demand |=> !gate_hi);

  assert_sign_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (current <= HPOS && current >= HNEG) |=> $stable(pos));

  always_comb
    if (rst_n) assert_clamp_R8: assert (cmp_out <= period);
endmodule

// File: tb/deadband_leg_test.sv
module deadband_leg_test;
  localparam int CW = 6, DTW = 3, IW = 8, HYST = 4;
  localparam int PER = 20;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] carrier = 0, period = PER[CW-1:0], compare = 0;
  logic [DTW-1:0] dead = 0;
  logic signed [IW-1:0] current = 0;
  logic gate_hi, gate_lo;
  logic [CW-1:0] cmp_out;

  deadband_leg #(.CW(CW), .DTW(DTW), .IW(IW), .HYST(HYST)) uut (
    .clk(clk), .rst_n(rst_n), .carrier(carrier), .period(period),
    .compare(compare), .dead(dead), .current(current),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .cmp_out(cmp_out));

  always #2 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;
  int m_pol = 1, m_s = 0, m_age = 0, m_gh = 0, m_gl = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (dead=%0d cmp=%0d carrier=%0d)",
               tag, act, exp, dead, compare, carrier);
    end
  endtask

  function automatic int corr(int pol, int c, int d, int p);
    int v = pol ? c + d : c - d;
    if (v < 0) v = 0;
    if (v > p) v = p;
    return v;
  endfunction

  task automatic step();
    int d;
    @(posedge clk);
    d = (int'(carrier) < corr(m_pol, compare, dead, period)) ? 1 : 0;
    if (d != m_s) begin m_s = d; m_age = 1; end
    else if (m_age < 1000) m_age++;
    m_gh = (d == 1 && m_age > dead) ? 1 : 0;
    m_gl = (d == 0 && m_age > dead) ? 1 : 0;
    if (current > HYST) m_pol = 1;
    else if (current < -HYST) m_pol = 0;
    @(negedge clk);
    chk(gate_hi == m_gh, "R3 R4 R5 R9 gate_hi", gate_hi, m_gh);
    chk(gate_lo == m_gl, "R3 R4 R9 gate_lo", gate_lo, m_gl);
    chk(!(gate_hi && gate_lo), "R2 overlap", int'(gate_hi & gate_lo), 0);
    chk(int'(cmp_out) == corr(m_pol, compare, dead, period), "R6 R7 R8 cmp_out",
        cmp_out, corr(m_pol, compare, dead, period));
  endtask

  function automatic logic signed [IW-1:0] cur_pat(int pat, int k);
    case (pat)
      0: return 8'sd30;
      1: return -8'sd30;
      2: return (k == 0) ? -8'sd9 : ((k % 3 == 0) ? 8'sd4 : ((k % 3 == 1) ? -8'sd4 : 8'sd0));
      default: begin
        int ph = (k / 7) % 4;
        if (ph == 0) return 8'sd6;
        if (ph == 1) return (k % 2) ? 8'sd3 : -8'sd3;
        if (ph == 2) return -8'sd5;
        return (k % 2) ? -8'sd2 : 8'sd4;
      end
    endcase
  endfunction

  initial begin
    #1;
    chk(gate_hi == 0 && gate_lo == 0, "R1 gates in reset", {gate_hi, gate_lo}, 0);
    compare = 7; dead = 2;
    #9;
    chk(int'(cmp_out) == 9, "R1 R7 reset sign positive", cmp_out, 9);
    @(negedge clk);
    rst_n = 1;
    chk(gate_hi == 0 && gate_lo == 0, "R1 gates after release", {gate_hi, gate_lo}, 0);
    // R5: negative current, compare 5, dead 3 -> corrected 2, shorter than dead band
    current = -8'sd20; dead = 3; compare = 5; carrier = 0;
    step();
    begin
      int hi_cnt = 0;
      for (int k = 0; k < 2 * PER; k++) begin
        carrier = CW'(k % PER);
        step();
        hi_cnt += gate_hi;
      end
      chk(hi_cnt == 0, "R5 short pulse suppressed", hi_cnt, 0);
    end
    for (int dt = 0; dt < 8; dt++)
      for (int c = 0; c <= PER + 2; c++)
        for (int pat = 0; pat < 4; pat++) begin
          dead = DTW'(dt); compare = CW'(c);
          for (int k = 0; k < 2 * PER; k++) begin
            carrier = CW'(k % PER);
            current = cur_pat(pat, k);
            step();
          end
        end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule